// File: doc/BRIEF.md
# DRAM Command Energy Accumulator

This block keeps a running energy total for one channel of a four-bank stacked DRAM. It watches the command stream that the memory controller issues, one command per clock at most, with a bank number attached. Every clock it charges three supply domains with the current that the channel draws in that cycle. The three domains are the 1.8 V array and pump supply, the 1.2 V core supply (command and address current is counted here), and the 1.2 V I/O supply. Each channel of a stack gets its own copy of the block. Power-down and self-refresh are outside its scope.

The current in a cycle has two parts. The first is a background level, which depends on whether any bank has an open row. The second is, for every operation still in its charging window, the amount by which that operation's current exceeds the matching background. The I/O domain carries only the data-transfer current of reads and writes. All currents (microamps), voltages (millivolts), the clock period (picoseconds) and the operation lengths (cycles) are configuration inputs. The energy added per cycle is current × voltage × period, shifted right by a fixed scale, so the result is counted in units of 2^ESHIFT zeptojoules.

A synchronous clear zeroes all three totals. A snapshot strobe copies all three totals at once into holding registers for readout.

Top module: `dram_energy_acc`

## Requirements
- R1: While reset is held, and at the first sample after reset, all three totals and all three snapshots read zero and every bank counts as closed.
- R2: A command is taken when `cmd_valid_i` is high at a rising edge. The `cmd_op_i` codes are 0 none, 1 ACT, 2 PRE, 3 RD, 4 WR and 5 REF, and `cmd_bank_i` selects the bank. Codes 6 and 7 are ignored, and so is any code presented while `cmd_valid_i` is low.
- R3: At each edge, each domain total grows by floor(I_uA × V_mV × T_ps / 2^ESHIFT), modulo 2^ACC_W, where I is that domain's current for the previous cycle. A command taken at edge k is first charged at edge k+2.
- R4: The background current in the array and core domains is IDD3N while any bank is open and IDD2N when all banks are closed. The I/O domain has no background.
- R5: ACT opens its bank and, for t_ras cycles, adds max(0, IDD0 − IDD3N) in the array and core domains.
- R6: PRE closes its bank and, for t_rp cycles, adds max(0, IDD0 − IDD2N) in the array and core domains.
- R7: RD adds, for t_burst cycles, max(0, IDD4R − IDD3N) in the array and core domains and the full IDD4R I/O current in the I/O domain. A length of zero adds nothing.
- R8: WR behaves like RD but uses the IDD4W currents.
- R9: REF adds max(0, IDD5 − IDD3N) in the array and core domains for t_rfc cycles. It ignores the bank field and leaves every bank's open state unchanged.
- R10: Operations on different banks, and a REF, all add their increments in the same cycle. A new RD or WR on a bank replaces any burst still running on that bank. A repeated ACT or PRE on a bank restarts its window.
- R11: When an operation current is below the background it is measured against, its increment is zero, never negative.
- R12: `clr_i` at an edge sets all three totals to zero after that edge, and the energy of that cycle is dropped.
- R13: `snap_i` at an edge copies the three totals, as they stood before that edge, into the snapshots. At every other edge the snapshots hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all totals |
| snap_i | input | 1 | Snapshot strobe |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Command code |
| cmd_bank_i | input | BANK_W | Target bank |
| idd0_arr_i | input | CUR_W | Activate/precharge current, array domain (uA) |
| idd0_core_i | input | CUR_W | Activate/precharge current, core domain |
| idd2n_arr_i | input | CUR_W | All-closed background, array domain |
| idd2n_core_i | input | CUR_W | All-closed background, core domain |
| idd3n_arr_i | input | CUR_W | Open-row background, array domain |
| idd3n_core_i | input | CUR_W | Open-row background, core domain |
| idd4r_arr_i | input | CUR_W | Read burst current, array domain |
| idd4r_core_i | input | CUR_W | Read burst current, core domain |
| idd4r_io_i | input | CUR_W | Read burst current, I/O domain |
| idd4w_arr_i | input | CUR_W | Write burst current, array domain |
| idd4w_core_i | input | CUR_W | Write burst current, core domain |
| idd4w_io_i | input | CUR_W | Write burst current, I/O domain |
| idd5_arr_i | input | CUR_W | Refresh current, array domain |
| idd5_core_i | input | CUR_W | Refresh current, core domain |
| volt_arr_i | input | VOLT_W | Array supply (mV) |
| volt_core_i | input | VOLT_W | Core supply (mV) |
| volt_io_i | input | VOLT_W | I/O supply (mV) |
| period_ps_i | input | PER_W | Clock period (ps) |
| t_ras_i | input | TIME_W | ACT charging length (cycles) |
| t_rp_i | input | TIME_W | PRE charging length |
| t_burst_i | input | TIME_W | RD/WR data-transfer length |
| t_rfc_i | input | TIME_W | REF charging length |
| acc_arr_o | output | ACC_W | Running total, array domain |
| acc_core_o | output | ACC_W | Running total, core domain |
| acc_io_o | output | ACC_W | Running total, I/O domain |
| snap_arr_o | output | ACC_W | Snapshot, array domain |
| snap_core_o | output | ACC_W | Snapshot, core domain |
| snap_io_o | output | ACC_W | Snapshot, I/O domain |

## Verification
A command taken at edge k loads its bank's window counter at that edge. The domain current is registered at edge k+1, and the total first moves at edge k+2. A clear or snapshot strobe takes effect at the edge that samples it. The bench keeps a behavioural model that advances at the same rising edges, with the same two-stage delay, and compares all six outputs with it at every falling edge, so each result is checked in the exact cycle it is due. The bench drives stimulus only on falling edges.

// File: rtl/dea_pkg.sv
package dea_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ACT  = 3'd1,
        OP_PRE  = 3'd2,
        OP_RD   = 3'd3,
        OP_WR   = 3'd4,
        OP_REF  = 3'd5
    } dram_op_e;

    localparam int unsigned NUM_DOM  = 3;
    localparam int unsigned DOM_ARR  = 0;
    localparam int unsigned DOM_CORE = 1;
    localparam int unsigned DOM_IO   = 2;

endpackage

// File: rtl/dea_bank.sv
module dea_bank
    import dea_pkg::*;
#(
    parameter int unsigned TIME_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_hit_i,
    input  dram_op_e          op_i,
    input  logic [TIME_W-1:0] t_ras_i,
    input  logic [TIME_W-1:0] t_rp_i,
    input  logic [TIME_W-1:0] t_burst_i,
    output logic              open_o,
    output logic              act_on_o,
    output logic              pre_on_o,
    output logic              rd_on_o,
    output logic              wr_on_o
);

    typedef struct packed {
        logic              open;
        logic [TIME_W-1:0] act_cnt;
        logic [TIME_W-1:0] pre_cnt;
        logic [TIME_W-1:0] rw_cnt;
        logic              rw_wr;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.act_cnt != '0) st_d.act_cnt = st_q.act_cnt - 1'b1;
        if (st_q.pre_cnt != '0) st_d.pre_cnt = st_q.pre_cnt - 1'b1;
        if (st_q.rw_cnt  != '0) st_d.rw_cnt  = st_q.rw_cnt  - 1'b1;
        if (cmd_hit_i) begin
            case (op_i)
                OP_ACT: begin
                    st_d.open    = 1'b1;
                    st_d.act_cnt = t_ras_i;
                end
                OP_PRE: begin
                    st_d.open    = 1'b0;
                    st_d.pre_cnt = t_rp_i;
                end
                OP_RD: begin
                    st_d.rw_cnt = t_burst_i;
                    st_d.rw_wr  = 1'b0;
                end
                OP_WR: begin
                    st_d.rw_cnt = t_burst_i;
                    st_d.rw_wr  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign open_o   = st_q.open;
    assign act_on_o = (st_q.act_cnt != '0);
    assign pre_on_o = (st_q.pre_cnt != '0);
    assign rd_on_o  = (st_q.rw_cnt != '0) && !st_q.rw_wr;
    assign wr_on_o  = (st_q.rw_cnt != '0) &&  st_q.rw_wr;

    // R5
    act_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_hit_i && op_i == OP_ACT) |=> open_o);

    // R6
    pre_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_hit_i && op_i == OP_PRE) |=> !open_o);

    // R9
    ref_keeps_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_hit_i && op_i == OP_REF) |=> (open_o == $past(open_o)));

endmodule

// File: rtl/dea_cur_sum.sv
module dea_cur_sum #(
    parameter int unsigned CUR_W = 20,
    parameter int unsigned CNT_W = 3,
    parameter int unsigned SUM_W = 25
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] n_act_i,
    input  logic [CNT_W-1:0] n_pre_i,
    input  logic [CNT_W-1:0] n_rd_i,
    input  logic [CNT_W-1:0] n_wr_i,
    input  logic             ref_on_i,
    input  logic             any_open_i,
    input  logic [CUR_W-1:0] idd0_i,
    input  logic [CUR_W-1:0] idd2n_i,
    input  logic [CUR_W-1:0] idd3n_i,
    input  logic [CUR_W-1:0] idd4r_i,
    input  logic [CUR_W-1:0] idd4w_i,
    input  logic [CUR_W-1:0] idd5_i,
    output logic [SUM_W-1:0] cur_o
);

    typedef struct packed {
        logic [SUM_W-1:0] cur;
    } sum_st_t;

    sum_st_t st_d, st_q;

    function automatic logic [CUR_W-1:0] above(input logic [CUR_W-1:0] op,
                                               input logic [CUR_W-1:0] base);
        return (op > base) ? (op - base) : '0;
    endfunction

    always_comb begin
        st_d.cur = any_open_i ? SUM_W'(idd3n_i) : SUM_W'(idd2n_i);
        st_d.cur = st_d.cur + SUM_W'(n_act_i) * SUM_W'(above(idd0_i,  idd3n_i));
        st_d.cur = st_d.cur + SUM_W'(n_pre_i) * SUM_W'(above(idd0_i,  idd2n_i));
        st_d.cur = st_d.cur + SUM_W'(n_rd_i)  * SUM_W'(above(idd4r_i, idd3n_i));
        st_d.cur = st_d.cur + SUM_W'(n_wr_i)  * SUM_W'(above(idd4w_i, idd3n_i));
        if (ref_on_i) st_d.cur = st_d.cur + SUM_W'(above(idd5_i, idd3n_i));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cur_o = st_q.cur;

    // R4
    open_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_open_i |=> (cur_o >= SUM_W'($past(idd3n_i))));

endmodule

// File: rtl/dea_dom_acc.sv
module dea_dom_acc #(
    parameter int unsigned SUM_W  = 25,
    parameter int unsigned VOLT_W = 12,
    parameter int unsigned PER_W  = 16,
    parameter int unsigned ACC_W  = 48,
    parameter int unsigned ESHIFT = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              snap_i,
    input  logic [SUM_W-1:0]  cur_i,
    input  logic [VOLT_W-1:0] volt_i,
    input  logic [PER_W-1:0]  period_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic [ACC_W-1:0]  snap_o
);

    localparam int unsigned PROD_W = SUM_W + VOLT_W + PER_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] snap;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(cur_i) * PROD_W'(volt_i) * PROD_W'(period_i);
        st_d = st_q;
        if (snap_i) st_d.snap = st_q.acc;
        if (clr_i) st_d.acc = '0;
        else       st_d.acc = st_q.acc + ACC_W'(prod >> ESHIFT);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign acc_o  = st_q.acc;
    assign snap_o = st_q.snap;

    // R12
    clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (acc_o == '0));

    // R13
    snap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        snap_i |=> (snap_o == $past(acc_o)));

    // R13
    snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !snap_i |=> $stable(snap_o));

endmodule

// File: rtl/dram_energy_acc.sv
module dram_energy_acc
    import dea_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned CUR_W     = 20,
    parameter int unsigned VOLT_W    = 12,
    parameter int unsigned PER_W     = 16,
    parameter int unsigned TIME_W    = 8,
    parameter int unsigned ACC_W     = 48,
    parameter int unsigned ESHIFT    = 10,
    localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              snap_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic [BANK_W-1:0] cmd_bank_i,
    input  logic [CUR_W-1:0]  idd0_arr_i,
    input  logic [CUR_W-1:0]  idd0_core_i,
    input  logic [CUR_W-1:0]  idd2n_arr_i,
    input  logic [CUR_W-1:0]  idd2n_core_i,
    input  logic [CUR_W-1:0]  idd3n_arr_i,
    input  logic [CUR_W-1:0]  idd3n_core_i,
    input  logic [CUR_W-1:0]  idd4r_arr_i,
    input  logic [CUR_W-1:0]  idd4r_core_i,
    input  logic [CUR_W-1:0]  idd4r_io_i,
    input  logic [CUR_W-1:0]  idd4w_arr_i,
    input  logic [CUR_W-1:0]  idd4w_core_i,
    input  logic [CUR_W-1:0]  idd4w_io_i,
    input  logic [CUR_W-1:0]  idd5_arr_i,
    input  logic [CUR_W-1:0]  idd5_core_i,
    input  logic [VOLT_W-1:0] volt_arr_i,
    input  logic [VOLT_W-1:0] volt_core_i,
    input  logic [VOLT_W-1:0] volt_io_i,
    input  logic [PER_W-1:0]  period_ps_i,
    input  logic [TIME_W-1:0] t_ras_i,
    input  logic [TIME_W-1:0] t_rp_i,
    input  logic [TIME_W-1:0] t_burst_i,
    input  logic [TIME_W-1:0] t_rfc_i,
    output logic [ACC_W-1:0]  acc_arr_o,
    output logic [ACC_W-1:0]  acc_core_o,
    output logic [ACC_W-1:0]  acc_io_o,
    output logic [ACC_W-1:0]  snap_arr_o,
    output logic [ACC_W-1:0]  snap_core_o,
    output logic [ACC_W-1:0]  snap_io_o
);

    localparam int unsigned CNT_W = $clog2(NUM_BANKS + 1);
    localparam int unsigned SUM_W = CUR_W + $clog2(4 * NUM_BANKS + 2);

    typedef struct packed {
        logic [TIME_W-1:0] ref_cnt;
    } top_st_t;

    top_st_t  st_d, st_q;
    dram_op_e op;
    logic     ref_on;

    assign op = dram_op_e'(cmd_op_i);

    always_comb begin
        st_d = st_q;
        if (st_q.ref_cnt != '0) st_d.ref_cnt = st_q.ref_cnt - 1'b1;
        if (cmd_valid_i && op == OP_REF) st_d.ref_cnt = t_rfc_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ref_on = (st_q.ref_cnt != '0);

    logic [NUM_BANKS-1:0] open_vec, act_vec, pre_vec, rd_vec, wr_vec;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = cmd_valid_i && (cmd_bank_i == BANK_W'(b));
        dea_bank #(.TIME_W(TIME_W)) u_bank (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .cmd_hit_i (hit),
            .op_i      (op),
            .t_ras_i   (t_ras_i),
            .t_rp_i    (t_rp_i),
            .t_burst_i (t_burst_i),
            .open_o    (open_vec[b]),
            .act_on_o  (act_vec[b]),
            .pre_on_o  (pre_vec[b]),
            .rd_on_o   (rd_vec[b]),
            .wr_on_o   (wr_vec[b])
        );
    end

    logic [CNT_W-1:0] n_act, n_pre, n_rd, n_wr;

    always_comb begin
        n_act = '0;
        n_pre = '0;
        n_rd  = '0;
        n_wr  = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            n_act = n_act + CNT_W'(act_vec[b]);
            n_pre = n_pre + CNT_W'(pre_vec[b]);
            n_rd  = n_rd  + CNT_W'(rd_vec[b]);
            n_wr  = n_wr  + CNT_W'(wr_vec[b]);
        end
    end

    logic [CUR_W-1:0]  d_idd0  [NUM_DOM];
    logic [CUR_W-1:0]  d_idd2n [NUM_DOM];
    logic [CUR_W-1:0]  d_idd3n [NUM_DOM];
    logic [CUR_W-1:0]  d_idd4r [NUM_DOM];
    logic [CUR_W-1:0]  d_idd4w [NUM_DOM];
    logic [CUR_W-1:0]  d_idd5  [NUM_DOM];
    logic [VOLT_W-1:0] d_volt  [NUM_DOM];
    logic [SUM_W-1:0]  d_cur   [NUM_DOM];
    logic [ACC_W-1:0]  d_acc   [NUM_DOM];
    logic [ACC_W-1:0]  d_snap  [NUM_DOM];

    assign d_idd0[DOM_ARR]   = idd0_arr_i;
    assign d_idd0[DOM_CORE]  = idd0_core_i;
    assign d_idd0[DOM_IO]    = '0;
    assign d_idd2n[DOM_ARR]  = idd2n_arr_i;
    assign d_idd2n[DOM_CORE] = idd2n_core_i;
    assign d_idd2n[DOM_IO]   = '0;
    assign d_idd3n[DOM_ARR]  = idd3n_arr_i;
    assign d_idd3n[DOM_CORE] = idd3n_core_i;
    assign d_idd3n[DOM_IO]   = '0;
    assign d_idd4r[DOM_ARR]  = idd4r_arr_i;
    assign d_idd4r[DOM_CORE] = idd4r_core_i;
    assign d_idd4r[DOM_IO]   = idd4r_io_i;
    assign d_idd4w[DOM_ARR]  = idd4w_arr_i;
    assign d_idd4w[DOM_CORE] = idd4w_core_i;
    assign d_idd4w[DOM_IO]   = idd4w_io_i;
    assign d_idd5[DOM_ARR]   = idd5_arr_i;
    assign d_idd5[DOM_CORE]  = idd5_core_i;
    assign d_idd5[DOM_IO]    = '0;
    assign d_volt[DOM_ARR]   = volt_arr_i;
    assign d_volt[DOM_CORE]  = volt_core_i;
    assign d_volt[DOM_IO]    = volt_io_i;

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        dea_cur_sum #(.CUR_W(CUR_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_sum (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .n_act_i    (n_act),
            .n_pre_i    (n_pre),
            .n_rd_i     (n_rd),
            .n_wr_i     (n_wr),
            .ref_on_i   (ref_on),
            .any_open_i (|open_vec),
            .idd0_i     (d_idd0[d]),
            .idd2n_i    (d_idd2n[d]),
            .idd3n_i    (d_idd3n[d]),
            .idd4r_i    (d_idd4r[d]),
            .idd4w_i    (d_idd4w[d]),
            .idd5_i     (d_idd5[d]),
            .cur_o      (d_cur[d])
        );
        dea_dom_acc #(.SUM_W(SUM_W), .VOLT_W(VOLT_W), .PER_W(PER_W),
                      .ACC_W(ACC_W), .ESHIFT(ESHIFT)) u_acc (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .clr_i    (clr_i),
            .snap_i   (snap_i),
            .cur_i    (d_cur[d]),
            .volt_i   (d_volt[d]),
            .period_i (period_ps_i),
            .acc_o    (d_acc[d]),
            .snap_o   (d_snap[d])
        );
    end

    assign acc_arr_o   = d_acc[DOM_ARR];
    assign acc_core_o  = d_acc[DOM_CORE];
    assign acc_io_o    = d_acc[DOM_IO];
    assign snap_arr_o  = d_snap[DOM_ARR];
    assign snap_core_o = d_snap[DOM_CORE];
    assign snap_io_o   = d_snap[DOM_IO];

    // R7
    io_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (n_rd == '0 && n_wr == '0) |=> (d_cur[DOM_IO] == '0));

    // R2
    bad_code_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i >= 3'd6) |=> $stable(open_vec));

    // R9
    ref_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && op == OP_REF && t_rfc_i != '0) |=> ref_on);

endmodule

// File: tb/dram_energy_acc_bench.sv
module dram_energy_acc_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB     = 4;
    localparam int CUR_W  = 20;
    localparam int VOLT_W = 12;
    localparam int PER_W  = 16;
    localparam int TIME_W = 8;
    localparam int ACC_W  = 48;
    localparam int ESHIFT = 10;
    localparam int WATCHDOG = 20000;
    localparam longint MASK = (64'sd1 <<< ACC_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, snap = 1'b0, cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic [CUR_W-1:0] idd0_arr = 20'd5880,  idd0_core = 20'd21180;
    logic [CUR_W-1:0] idd2n_arr = 20'd130,  idd2n_core = 20'd4040;
    logic [CUR_W-1:0] idd3n_arr = 20'd520,  idd3n_core = 20'd6550;
    logic [CUR_W-1:0] idd4r_arr = 20'd1410, idd4r_core = 20'd70270, idd4r_io = 20'd15460;
    logic [CUR_W-1:0] idd4w_arr = 20'd1500, idd4w_core = 20'd65000, idd4w_io = 20'd9000;
    logic [CUR_W-1:0] idd5_arr = 20'd6260,  idd5_core = 20'd28170;
    logic [VOLT_W-1:0] volt_arr = 12'd1800, volt_core = 12'd1200, volt_io = 12'd1200;
    logic [PER_W-1:0] period = 16'd5000;
    logic [TIME_W-1:0] t_ras = 8'd8, t_rp = 8'd3, t_burst = 8'd2, t_rfc = 8'd12;
    logic [ACC_W-1:0] acc_arr, acc_core, acc_io, snap_arr, snap_core, snap_io;

    dram_energy_acc u_dram_energy_acc (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .snap_i(snap),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_bank_i(cmd_bank),
        .idd0_arr_i(idd0_arr), .idd0_core_i(idd0_core),
        .idd2n_arr_i(idd2n_arr), .idd2n_core_i(idd2n_core),
        .idd3n_arr_i(idd3n_arr), .idd3n_core_i(idd3n_core),
        .idd4r_arr_i(idd4r_arr), .idd4r_core_i(idd4r_core), .idd4r_io_i(idd4r_io),
        .idd4w_arr_i(idd4w_arr), .idd4w_core_i(idd4w_core), .idd4w_io_i(idd4w_io),
        .idd5_arr_i(idd5_arr), .idd5_core_i(idd5_core),
        .volt_arr_i(volt_arr), .volt_core_i(volt_core), .volt_io_i(volt_io),
        .period_ps_i(period), .t_ras_i(t_ras), .t_rp_i(t_rp),
        .t_burst_i(t_burst), .t_rfc_i(t_rfc),
        .acc_arr_o(acc_arr), .acc_core_o(acc_core), .acc_io_o(acc_io),
        .snap_arr_o(snap_arr), .snap_core_o(snap_core), .snap_io_o(snap_io)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    string phase = "R1";
    bit finished = 1'b0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int act_c [NB];
    int pre_c [NB];
    int rw_c  [NB];
    bit rw_w  [NB];
    bit open_m[NB];
    int ref_c;
    longint cur_m [3];
    longint acc_m [3];
    longint snap_m[3];

    function automatic longint above(input longint a, input longint b);
        return (a > b) ? a - b : 0;
    endfunction

    // k: 0 activate, 1 closed bg, 2 open bg, 3 read, 4 write, 5 refresh
    function automatic longint cfg(input int d, input int k);
        case (k)
            0: return d == 0 ? longint'(idd0_arr)  : d == 1 ? longint'(idd0_core)  : 0;
            1: return d == 0 ? longint'(idd2n_arr) : d == 1 ? longint'(idd2n_core) : 0;
            2: return d == 0 ? longint'(idd3n_arr) : d == 1 ? longint'(idd3n_core) : 0;
            3: return d == 0 ? longint'(idd4r_arr) : d == 1 ? longint'(idd4r_core) : longint'(idd4r_io);
            4: return d == 0 ? longint'(idd4w_arr) : d == 1 ? longint'(idd4w_core) : longint'(idd4w_io);
            default: return d == 0 ? longint'(idd5_arr) : d == 1 ? longint'(idd5_core) : 0;
        endcase
    endfunction

    function automatic longint volt(input int d);
        return d == 0 ? longint'(volt_arr) : d == 1 ? longint'(volt_core) : longint'(volt_io);
    endfunction

    function automatic longint model_current(input int d);
        longint c;
        bit any_open = 1'b0;
        for (int b = 0; b < NB; b++) any_open |= open_m[b];
        c = any_open ? cfg(d, 2) : cfg(d, 1);
        for (int b = 0; b < NB; b++) begin
            if (act_c[b] > 0) c += above(cfg(d, 0), cfg(d, 2));
            if (pre_c[b] > 0) c += above(cfg(d, 0), cfg(d, 1));
            if (rw_c[b] > 0)  c += above(cfg(d, rw_w[b] ? 4 : 3), cfg(d, 2));
        end
        if (ref_c > 0) c += above(cfg(d, 5), cfg(d, 2));
        return c;
    endfunction

    always @(posedge clk) begin
        longint nc [3];
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                act_c[b] = 0; pre_c[b] = 0; rw_c[b] = 0; rw_w[b] = 0; open_m[b] = 0;
            end
            ref_c = 0;
            for (int d = 0; d < 3; d++) begin
                cur_m[d] = 0; acc_m[d] = 0; snap_m[d] = 0;
            end
        end else begin
            for (int d = 0; d < 3; d++) nc[d] = model_current(d);
            for (int d = 0; d < 3; d++) begin
                longint e;
                e = (cur_m[d] * volt(d) * longint'(period)) >>> ESHIFT;
                if (snap) snap_m[d] = acc_m[d];
                acc_m[d] = clr ? 0 : ((acc_m[d] + e) & MASK);
                cur_m[d] = nc[d];
            end
            for (int b = 0; b < NB; b++) begin
                if (act_c[b] > 0) act_c[b]--;
                if (pre_c[b] > 0) pre_c[b]--;
                if (rw_c[b] > 0)  rw_c[b]--;
            end
            if (ref_c > 0) ref_c--;
            if (cmd_valid) begin
                case (cmd_op)
                    3'd1: begin open_m[cmd_bank] = 1; act_c[cmd_bank] = int'(t_ras); end
                    3'd2: begin open_m[cmd_bank] = 0; pre_c[cmd_bank] = int'(t_rp); end
                    3'd3: begin rw_c[cmd_bank] = int'(t_burst); rw_w[cmd_bank] = 0; end
                    3'd4: begin rw_c[cmd_bank] = int'(t_burst); rw_w[cmd_bank] = 1; end
                    3'd5: ref_c = int'(t_rfc);
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(phase, "acc_arr",   longint'(acc_arr),   acc_m[0]);
            chk(phase, "acc_core",  longint'(acc_core),  acc_m[1]);
            chk(phase, "acc_io",    longint'(acc_io),    acc_m[2]);
            chk(phase, "snap_arr",  longint'(snap_arr),  snap_m[0]);
            chk(phase, "snap_core", longint'(snap_core), snap_m[1]);
            chk(phase, "snap_io",   longint'(snap_io),   snap_m[2]);
        end
    end

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] bank);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic pulse_snap(input bit with_clear);
        @(negedge clk);
        snap = 1'b1; clr = with_clear;
        @(negedge clk);
        snap = 1'b0; clr = 1'b0;
    endtask

    initial begin
        // R1: reset state
        idle(3);
        chk("R1", "acc_arr in reset",  longint'(acc_arr),  0);
        chk("R1", "acc_core in reset", longint'(acc_core), 0);
        chk("R1", "acc_io in reset",   longint'(acc_io),   0);
        chk("R1", "snap_core in reset", longint'(snap_core), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R4: all-closed background only
        phase = "R4"; idle(6);
        chk("R4", "io idle total", longint'(acc_io), 0);
        // R5: activate bank 0, window and open background
        phase = "R5"; issue(3'd1, 2'd0); idle(12);
        // R7: read burst on open bank
        phase = "R7"; issue(3'd3, 2'd0); idle(5);
        // R8: write burst
        phase = "R8"; issue(3'd4, 2'd0); idle(5);
        // R10: overlap across banks and restart on same bank
        phase = "R10";
        issue(3'd1, 2'd1);
        issue(3'd3, 2'd0);
        issue(3'd4, 2'd1);
        issue(3'd1, 2'd2);
        t_burst = 8'd4;
        issue(3'd3, 2'd0);
        issue(3'd4, 2'd0);
        idle(10);
        // R9: refresh with a bank field, open state kept
        phase = "R9"; issue(3'd5, 2'd3); idle(3); issue(3'd1, 2'd3); idle(14);
        // R6: precharge every bank, then closed background
        phase = "R6";
        for (int b = 0; b < NB; b++) issue(3'd2, 2'(b));
        idle(8);
        // R2: ignored codes and commands without valid
        phase = "R2";
        issue(3'd6, 2'd0); issue(3'd7, 2'd2);
        @(negedge clk); cmd_valid = 1'b0; cmd_op = 3'd1; cmd_bank = 2'd3;
        @(negedge clk); cmd_op = 3'd0;
        idle(4);
        chk("R2", "io total unchanged by ignored commands", longint'(acc_io), acc_m[2]);
        // R11: operation current below background
        phase = "R11";
        issue(3'd1, 2'd0);
        idd4w_core = 20'd1000;
        idd0_arr = 20'd100;
        issue(3'd4, 2'd0); issue(3'd2, 2'd1); idle(10);
        idd4w_core = 20'd65000; idd0_arr = 20'd5880;
        // R7: zero-length burst adds nothing beyond background
        phase = "R7"; t_burst = 8'd0; issue(3'd3, 2'd0); idle(4); t_burst = 8'd2;
        // R13: snapshot
        phase = "R13"; pulse_snap(1'b0); idle(3);
        chk("R13", "snap_core held", longint'(snap_core), snap_m[1]);
        // R12: clear together with snapshot, then clear alone during a burst
        phase = "R12"; pulse_snap(1'b1);
        chk("R12", "acc_core after clear", longint'(acc_core), 0);
        issue(3'd3, 2'd0);
        @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
        chk("R12", "acc_io after clear", longint'(acc_io), 0);
        idle(6);
        // R3: long run with refresh and bursts, energy keeps scaling
        phase = "R3";
        period = 16'd2500;
        for (int i = 0; i < 20; i++) begin
            issue(3'(3 + (i % 2)), 2'(i % NB));
            if (i % 7 == 0) issue(3'd5, 2'd0);
        end
        idle(20);
        pulse_snap(1'b0);
        idle(2);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule